// File: doc/BRIEF.md
# Multi-Mode Timer Bank with Channel-Linked Prescalers

The block holds a set of 16-bit down-counting timer channels behind a small register interface. Each channel runs in one of three modes. In periodic mode it raises an interrupt pulse at a fixed rate and reloads itself. In watchdog mode it raises a sticky reset request if software fails to restart it in time. In event mode it counts edges on an external input and raises an interrupt when the count runs out.

Each channel takes its count clock from one of three sources: every core clock, a prescaled tick, or the rising edges of its own external input. Only the first channels have a prescaler. Each prescaler is owned by exactly one channel. It restarts whenever that channel's initial value is written or the channel reloads itself, so the first prescaled tick after a load always arrives one full prescale period later. External inputs pass through a two-flop synchroniser and an edge detector before they are used.

Top module: `tmr_bank`

## Requirements
- R1: After reset, all counts, initial values, control and divide registers read 0, `irq` is 0 and `wdt_req` is 0.
- R2: Periodic mode (mode 00, or 11) counts one step per tick. A tick that finds the count at 1 or 0 reloads the initial value I and pulses `irq` high for one cycle. The interrupt period is therefore I ticks for I >= 1, and every tick for I = 0.
- R3: Clock select (control bits 4:3) works as follows. 00 gives a tick on every core clock. 01 gives the prescaled tick on channels below NUM_PRE, and every core clock on the other channels. 10 gives one tick per synchronised rising edge of the channel's `ext_in` bit. 11 gives every core clock.
- R4: A prescaler with divide value D (register 2, bits 7:0) gives one tick every D+1 enabled core clocks.
- R5: A write to a channel's initial value, and every periodic reload, resets the linked prescaler's phase to zero. The first tick after a load then falls D+1 clocks after the load edge.
- R6: An external input is synchronised through two flops. It counts exactly once per rising edge, however long it stays high.
- R7: Watchdog mode (mode 01) sets `wdt_req` when a tick finds the count at 1, and never pulses `irq`. `wdt_req` stays high until reset. Rewriting the initial value restarts the count from that value.
- R8: Event mode (mode 10) decrements once per external rising edge, whatever the clock select. It pulses `irq` once when the count reaches 0 and then holds at 0.
- R9: With the enable bit (control bit 0) clear, the channel's count and its prescaler both hold.
- R10: The address is {channel, reg}. Reg 0 is the initial value (a write also loads the count). Reg 1 is control. Reg 2 is the divide value, which reads 0 and ignores writes on channels without a prescaler. Reg 3 is the live count, read-only. `rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | {channel, register} select |
| wdata | input | CNT_W (16) | Write data |
| rdata | output | CNT_W (16) | Registered read data |
| ext_in | input | NUM_CH (4) | Per-channel asynchronous external clock/event input |
| irq | output | NUM_CH (4) | Per-channel one-cycle interrupt pulse |
| wdt_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench uses the default build: four 16-bit channels, two 8-bit prescalers, and therefore two channels with no prescaled option. Small initial values (0 to 5) and divide values (0 to 3) keep whole interrupt periods within a few dozen cycles. This lets every channel, clock source and mode be swept, with interrupt counts predicted as window length divided by period. The two prescaler-less channels make the fallback of clock select 01 reachable. A mid-period reload pins down the prescaler restart to the exact cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_PERIODIC     = 2'b00,
    MODE_WDOG         = 2'b01,
    MODE_EVENT        = 2'b10,
    MODE_PERIODIC_ALT = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_CORE     = 2'b00,
    SRC_PRESCALE = 2'b01,
    SRC_EXT      = 2'b10,
    SRC_CORE_ALT = 2'b11
  } tmr_src_e;

  // bit 4:3 source, bit 2:1 mode, bit 0 enable
  typedef struct packed {
    tmr_src_e  src;
    tmr_mode_e mode;
    logic      en;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] REG_LOAD  = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;
  localparam logic [1:0] REG_DIV   = 2'd2;
  localparam logic [1:0] REG_COUNT = 2'd3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] phase_q;

  assign tick = en && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (en) begin
      if (phase_q >= div) phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
    end
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0)); // R5

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> $stable(phase_q)); // R9

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [2:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[1:0], async_in};
  end

  assign rise = shift_q[1] && !shift_q[2];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R6

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  tmr_mode_e        mode,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] init_val,
  output logic             restart,
  output logic             irq,
  output logic             wdt
);

  logic [CNT_W-1:0] count_q, init_q;
  logic             irq_q, wdt_q;
  logic             periodic, step, at_end, expire;

  always_comb begin
    periodic = (mode == MODE_PERIODIC) || (mode == MODE_PERIODIC_ALT);
    step     = en && tick;
    at_end   = periodic ? (count_q <= CNT_W'(1)) : (count_q == CNT_W'(1));
    expire   = step && at_end && !load;
    restart  = load || (expire && periodic);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      init_q  <= '0;
      irq_q   <= 1'b0;
      wdt_q   <= 1'b0;
    end else begin
      irq_q <= expire && (mode != MODE_WDOG);
      if (expire && (mode == MODE_WDOG)) wdt_q <= 1'b1;
      if (load) begin
        count_q <= load_val;
        init_q  <= load_val;
      end else if (expire && periodic) begin
        count_q <= init_q;
      end else if (step && (count_q != '0)) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assign count    = count_q;
  assign init_val = init_q;
  assign irq      = irq_q;
  assign wdt      = wdt_q;

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (irq_q && $past(periodic)) |-> (count_q == init_q)); // R2

  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (rst)
    wdt_q |=> wdt_q); // R7

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(count_q)); // R9

  AST_EVENT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_EVENT) && (count_q == '0) && !load) |=> (count_q == '0)); // R8

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8,
  parameter int NUM_PRE = 2,
  localparam int SEL_W  = $clog2(NUM_CH),
  localparam int ADDR_W = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic [NUM_CH-1:0] ext_in,
  output logic [NUM_CH-1:0] irq,
  output logic              wdt_req
);

  logic [SEL_W-1:0] ch_sel;
  logic [1:0]       reg_sel;
  assign ch_sel  = addr[ADDR_W-1:2];
  assign reg_sel = addr[1:0];

  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_vec, init_vec;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_vec;
  logic [NUM_CH-1:0][DIV_W-1:0]  div_vec;
  logic [NUM_CH-1:0]             wdt_vec;
  logic [CNT_W-1:0]              rd_next;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_ctrl_t ctrl_q;
    logic      wr_hit, ext_rise, pre_tick, src_tick, restart;

    assign wr_hit = wr_en && (ch_sel == SEL_W'(c));

    always_ff @(posedge clk) begin
      if (rst)                               ctrl_q <= '0;
      else if (wr_hit && reg_sel == REG_CTRL) ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    end
    assign ctrl_vec[c] = ctrl_q;

    tmr_edge_sync u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ext_in[c]),
      .rise     (ext_rise)
    );

    if (c < NUM_PRE) begin : g_pre
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                               div_q <= '0;
        else if (wr_hit && reg_sel == REG_DIV) div_q <= wdata[DIV_W-1:0];
      end
      assign div_vec[c] = div_q;

      tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.en),
        .restart (restart),
        .div     (div_q),
        .tick    (pre_tick)
      );
    end else begin : g_nopre
      assign div_vec[c] = '0;
      assign pre_tick   = 1'b0;
    end

    always_comb begin
      if (ctrl_q.mode == MODE_EVENT) begin
        src_tick = ext_rise;
      end else begin
        case (ctrl_q.src)
          SRC_PRESCALE: src_tick = (c < NUM_PRE) ? pre_tick : 1'b1;
          SRC_EXT:      src_tick = ext_rise;
          default:      src_tick = 1'b1;
        endcase
      end
    end

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .en       (ctrl_q.en),
      .mode     (ctrl_q.mode),
      .tick     (src_tick),
      .load     (wr_hit && (reg_sel == REG_LOAD)),
      .load_val (wdata),
      .count    (cnt_vec[c]),
      .init_val (init_vec[c]),
      .restart  (restart),
      .irq      (irq[c]),
      .wdt      (wdt_vec[c])
    );
  end

  always_comb begin
    case (reg_sel)
      REG_LOAD: rd_next = init_vec[ch_sel];
      REG_CTRL: rd_next = CNT_W'(ctrl_vec[ch_sel]);
      REG_DIV:  rd_next = CNT_W'(div_vec[ch_sel]);
      default:  rd_next = cnt_vec[ch_sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign wdt_req = |wdt_vec;

  AST_WDT_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    wdt_req |=> wdt_req); // R7

endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [3:0]        addr = '0;
  logic [CNT_W-1:0]  wdata = '0;
  logic [CNT_W-1:0]  rdata;
  logic [NUM_CH-1:0] ext_in = '0;
  logic [NUM_CH-1:0] irq;
  logic              wdt_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_in(ext_in), .irq(irq), .wdt_req(wdt_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input int ch, input int r, input int val);
    wr_en = 1'b1; addr = 4'((ch << 2) | r); wdata = CNT_W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, output int v);
    addr = 4'((ch << 2) | r);
    @(negedge clk);
    v = int'(rdata);
  endtask

  // control word: src<<3 | mode<<1 | en
  function automatic int cw(input int src, input int mode, input int en);
    return (src << 3) | (mode << 1) | en;
  endfunction

  initial begin
    int v, n, first;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 wdt_req", int'(wdt_req), 0);
    for (int a = 0; a < 16; a++) begin
      rd(a >> 2, a & 3, v);
      chk("R1 reg", v, 0);
    end

    // R2 periodic, internal clock, sweep of initial values on every channel
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int init = 0; init <= 5; init++) begin
        wr(ch, 0, init);
        wr(ch, 1, cw(0, (init == 4) ? 3 : 0, 1));
        n = 0;
        for (int i = 1; i <= 24; i++) begin
          @(negedge clk); n += int'(irq[ch]);
        end
        chk("R2 periodic irq count", n, (init == 0) ? 24 : 24 / init);
        wr(ch, 1, 0);
        @(negedge clk);
      end
    end

    // R3 source 11 everywhere, source 01 on channels without prescaler
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int s = 1; s <= 3; s += 2) begin
        if (s == 1 && ch < 2) continue;
        wr(ch, 0, 3);
        wr(ch, 1, cw(s, 0, 1));
        n = 0;
        for (int i = 1; i <= 24; i++) begin
          @(negedge clk); n += int'(irq[ch]);
        end
        chk("R3 core-rate source", n, 8);
        wr(ch, 1, 0);
        @(negedge clk);
      end
    end

    // R4 prescaled clock on channels 0 and 1
    for (int ch = 0; ch < 2; ch++) begin
      for (int d = 0; d <= 3; d++) begin
        for (int init = 1; init <= 3; init++) begin
          wr(ch, 2, d);
          wr(ch, 0, init);
          wr(ch, 1, cw(1, 0, 1));
          n = 0;
          for (int i = 1; i <= 48; i++) begin
            @(negedge clk); n += int'(irq[ch]);
          end
          chk("R4 prescaled irq count", n, 48 / (init * (d + 1)));
          wr(ch, 1, 0);
          @(negedge clk);
        end
      end
    end

    // R5 prescaler restart on a mid-period load
    wr(0, 2, 3);
    wr(0, 0, 2);
    wr(0, 1, cw(1, 0, 1));
    @(negedge clk); @(negedge clk);
    wr(0, 0, 2);
    first = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (irq[0] && first == 0) first = i;
    end
    chk("R5 first irq after load", first, 8);
    wr(0, 1, 0);

    // R9 + R10 freeze and live count readback
    wr(0, 0, 100);
    wr(0, 1, cw(0, 0, 1));
    repeat (10) @(negedge clk);
    wr(0, 1, 0);
    rd(0, 3, v);
    chk("R9 count at disable", v, 89);
    repeat (20) @(negedge clk);
    rd(0, 3, v);
    chk("R9 count frozen", v, 89);
    rd(0, 0, v);
    chk("R10 initial readback", v, 100);
    rd(0, 2, v);
    chk("R10 divide readback", v, 3);
    wr(1, 1, cw(2, 2, 1) & 16'h1e);
    rd(1, 1, v);
    chk("R10 control readback", v, 16'h14);
    wr(1, 1, 0);
    wr(2, 2, 5);
    rd(2, 2, v);
    chk("R10 divide absent reads 0", v, 0);

    // R3 external source in periodic mode, channel 1, 4 edges, init 2
    wr(1, 0, 2);
    wr(1, 1, cw(2, 0, 1));
    n = 0;
    for (int p = 0; p < 4; p++) begin
      ext_in[1] = 1'b1;
      repeat (3) begin @(negedge clk); n += int'(irq[1]); end
      ext_in[1] = 1'b0;
      repeat (3) begin @(negedge clk); n += int'(irq[1]); end
    end
    repeat (4) begin @(negedge clk); n += int'(irq[1]); end
    chk("R3 external source irq count", n, 2);
    wr(1, 1, 0);

    // R8 + R6 event mode on channel 2, clock select ignored, long pulses
    wr(2, 0, 3);
    wr(2, 1, cw(0, 2, 1));
    n = 0;
    for (int p = 0; p < 5; p++) begin
      ext_in[2] = 1'b1;
      repeat (5) begin @(negedge clk); n += int'(irq[2]); end
      ext_in[2] = 1'b0;
      repeat (4) begin @(negedge clk); n += int'(irq[2]); end
      rd(2, 3, v);
      chk("R6 R8 event count", v, (3 - (p + 1) < 0) ? 0 : 3 - (p + 1));
    end
    chk("R8 event irq count", n, 1);
    wr(2, 1, 0);

    // R7 watchdog on channel 3: kick, then expire
    chk("R7 wdt_req low before", int'(wdt_req), 0);
    wr(3, 0, 5);
    wr(3, 1, cw(0, 1, 1));
    repeat (3) @(negedge clk);
    wr(3, 0, 5);
    n = 0;
    for (int i = 1; i <= 5; i++) begin
      if (i == 5) chk("R7 wdt_req before expiry", int'(wdt_req), 0);
      @(negedge clk);
      n += int'(irq[3]);
      if (i == 4) chk("R7 wdt_req after kick", int'(wdt_req), 0);
    end
    chk("R7 wdt_req at expiry", int'(wdt_req), 1);
    wr(3, 0, 5);
    repeat (3) begin @(negedge clk); n += int'(irq[3]); end
    chk("R7 wdt_req sticky", int'(wdt_req), 1);
    chk("R7 no irq in watchdog", n, 0);

    // R1 reset clears sticky request and state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 wdt_req after reset", int'(wdt_req), 0);
    rd(3, 3, v);
    chk("R1 count after reset", v, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule